// File: doc/BRIEF.md
# Memory-Mapped Port Output and Input Data Block

This block gives software control of 32 general-purpose output lines and a view of 32 input lines through a small register bus. The bus has a word address, a write strobe, write data and combinational read data. A write to the output word replaces every output bit. Three mask words change only chosen bits: one sets them, one clears them and one inverts them. Because of this, a driver can change one line without reading the word first and without racing another writer.

The input lines are asynchronous to the block clock. Each one passes through two flops before the input word shows it. A read returns the value selected by the address in the same cycle. A write takes effect at the clock edge where the strobe is high. The output lines are driven straight from the output register.

Top module: `pio_data_port`

## Requirements
- R1: After a synchronous active-low reset, the output register and the output lines are all zero.
- R2: A write to address 0x00 replaces all 32 output bits with the write data at that edge. A read of 0x00 returns the output register.
- R3: A write to address 0x04 sets each output bit whose data bit is 1. All other output bits keep their values.
- R4: A write to address 0x08 clears each output bit whose data bit is 1. All other output bits keep their values.
- R5: A write to address 0x0C inverts each output bit whose data bit is 1. All other output bits keep their values.
- R6: A read of address 0x10 returns the synchronized input levels, with bit n taken from input line n. A change on an input line appears there two clock edges later.
- R7: Reads of 0x04, 0x08 and 0x0C return zero. A read of any unmapped address also returns zero.
- R8: A write to 0x10 or to an unmapped address leaves the output register unchanged.
- R9: When the write strobe is low, the output register does not change.
- R10: Read data is a combinational function of the address and the current register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data |
| pin_in | input | 32 | Asynchronous input lines |
| pin_out | output | 32 | Output line levels |

## Verification
The hardest case to bring about is a mask write that must leave some bits alone while changing others. This needs an output word that already holds a mix of ones and zeros. The bench first loads a known mixed pattern through a full write. It then applies set, clear and toggle masks that overlap both the ones and the zeros, and compares the result with a model word after each step. The two-edge input latency is checked by changing the lines just after an edge and sampling after exactly one edge and then after a second edge.

// File: rtl/pio_pkg.sv
// Package: shared widths and register offsets of the port data block.
// Assumes word-aligned byte addresses on an 8-bit address bus.
package pio_pkg;
    localparam int unsigned PIO_ADDR_W = 8;
    localparam logic [PIO_ADDR_W-1:0] OFS_DATA   = 8'h00;
    localparam logic [PIO_ADDR_W-1:0] OFS_SETM   = 8'h04;
    localparam logic [PIO_ADDR_W-1:0] OFS_CLRM   = 8'h08;
    localparam logic [PIO_ADDR_W-1:0] OFS_TOGM   = 8'h0C;
    localparam logic [PIO_ADDR_W-1:0] OFS_INPUT  = 8'h10;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_SET   = 3'd2,
        OP_CLEAR = 3'd3,
        OP_FLIP  = 3'd4
    } pio_op_e;
endpackage

// File: rtl/pio_sync.sv
// Module: pio_sync
// Brings WIDTH asynchronous lines into the clock domain through STAGES flops.
// Assumes each line is a level that is held for longer than STAGES cycles.
module pio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the line levels along the flop chain, resetting to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];

    // R6: a stable input reaches the output after two edges.
    if (STAGES == 2) begin : g_chk2
        assert_sync_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(async_in) && $past(rst_n) |=> sync_out == $past(async_in))
            else $error("sync latency");
    end
endmodule

// File: rtl/pio_decode.sv
// Module: pio_decode
// Turns a bus strobe and an address into one update operation for the output
// register. Assumes aligned addresses; an unmapped or read-only write is OP_NONE.
module pio_decode
    import pio_pkg::*;
(
    input  logic [PIO_ADDR_W-1:0] addr,
    input  logic                  wr,
    output pio_op_e               op
);
    // Select the output update for this bus cycle.
    always_comb begin
        op = OP_NONE;
        if (wr) begin
            unique case (addr)
                OFS_DATA: op = OP_LOAD;
                OFS_SETM: op = OP_SET;
                OFS_CLRM: op = OP_CLEAR;
                OFS_TOGM: op = OP_FLIP;
                default:  op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pio_out_reg.sv
// Module: pio_out_reg
// Holds the output word and applies load, set, clear and toggle updates.
// Assumes at most one operation per cycle, which the decoder provides.
module pio_out_reg
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pio_op_e          op,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    // Work out the next output word from the operation and the mask.
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = value;
            OP_SET:   nxt = q | value;
            OP_CLEAR: nxt = q & ~value;
            OP_FLIP:  nxt = q ^ value;
            default:  nxt = q;
        endcase
    end

    // Register the output word; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> q == '0) else $error("reset value");
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_NONE |=> $stable(q)) else $error("hold");
    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SET |=> ((q & $past(value)) == $past(value))
                      && ((q & ~$past(value)) == ($past(q) & ~$past(value))))
        else $error("set");
    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CLEAR |=> ((q & $past(value)) == '0)
                        && ((q & ~$past(value)) == ($past(q) & ~$past(value))))
        else $error("clear");
    assert_toggle_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FLIP |=> (q ^ $past(q)) == $past(value)) else $error("toggle");
endmodule

// File: rtl/pio_data_port.sv
// Module: pio_data_port
// 32-line output and input data block on a simple register bus. Writes act at
// the strobe edge, reads are combinational. Assumes word-aligned addresses.
module pio_data_port
    import pio_pkg::*;
#(
    parameter int unsigned NPINS     = 32,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIO_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [NPINS-1:0]      bus_wdata,
    output logic [NPINS-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out
);
    pio_op_e          op;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] in_sync;

    pio_decode u_dec (.addr(bus_addr), .wr(bus_wr), .op(op));

    pio_out_reg #(.WIDTH(NPINS)) u_out (
        .clk(clk), .rst_n(rst_n), .op(op), .value(bus_wdata), .q(out_q));

    pio_sync #(.WIDTH(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(in_sync));

    // Read multiplexer: the mask words and unmapped addresses return zero.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA:  bus_rdata = out_q;
            OFS_INPUT: bus_rdata = in_sync;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;

    assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_DATA |=> pin_out == $past(bus_wdata))
        else $error("load");
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr > OFS_TOGM |=> $stable(pin_out)) else $error("ro write");
    always_comb begin
        if (rst_n && (bus_addr == OFS_SETM || bus_addr == OFS_CLRM || bus_addr == OFS_TOGM))
            assert_mask_read_zero_R7: assert (bus_rdata == '0) else $error("mask read");
    end
endmodule

// File: tb/sim_pio_data_port.sv
module sim_pio_data_port;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = 0;
    logic [31:0] pin_out;
    int checks = 0, fails = 0;
    logic [31:0] model = 0;

    always #5 clk = ~clk;

    pio_data_port u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus write; inputs change at the falling edge, taking effect at the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1 pins", pin_out, 32'h0);
        rd(8'h00, r); chk("R1 read", r, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] r;
        wr(8'h00, 32'hA5A5_0F0F); model = 32'hA5A5_0F0F;
        chk("R2 pins", pin_out, model);
        rd(8'h00, r); chk("R2 read", r, model);
    endtask

    task automatic t_masks();
        wr(8'h04, 32'h0000_FF00); model |= 32'h0000_FF00;  chk("R3 set", pin_out, model);
        wr(8'h08, 32'hFF00_00F0); model &= ~32'hFF00_00F0; chk("R4 clear", pin_out, model);
        wr(8'h0C, 32'h8001_8001); model ^= 32'h8001_8001;  chk("R5 toggle", pin_out, model);
        wr(8'h0C, 32'h8001_8001); model ^= 32'h8001_8001;  chk("R5 toggle back", pin_out, model);
    endtask

    task automatic t_reads();
        logic [31:0] r;
        rd(8'h04, r); chk("R7 set read", r, 0);
        rd(8'h08, r); chk("R7 clear read", r, 0);
        rd(8'h0C, r); chk("R7 toggle read", r, 0);
        rd(8'h40, r); chk("R7 unmapped read", r, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] r;
        wr(8'h10, 32'hFFFF_FFFF); chk("R8 input write", pin_out, model);
        wr(8'h20, 32'h1234_5678); chk("R8 unmapped write", pin_out, model);
        @(negedge clk); bus_addr = 8'h00; bus_wdata = 32'hDEAD_BEEF; bus_wr = 0;
        @(negedge clk); chk("R9 no strobe", pin_out, model);
        rd(8'h00, r); chk("R10 comb read", r, model);
    endtask

    task automatic t_input();
        logic [31:0] r;
        @(negedge clk); bus_addr = 8'h10; pin_in = 32'hC0DE_0001;
        @(negedge clk); #1 chk("R6 after one edge", bus_rdata, 32'h0);
        @(negedge clk); #1 chk("R6 after two edges", bus_rdata, 32'hC0DE_0001);
        pin_in = 32'h8000_0000; repeat (3) @(negedge clk);
        rd(8'h10, r); chk("R6 bit31", r, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_load(); t_masks(); t_reads(); t_ignored(); t_input();
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1 re-reset", pin_out, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule